// File: doc/BRIEF.md
# Dual-Pipe Banked Data Store Arbiter

This block sits between two parallel execution pipes and a word-organised data store. Each cycle, a primary pipe and a secondary pipe can each present one load or store. Storage is not a two-port memory. It is split into several single-ported banks, and consecutive words go to consecutive banks. When the two accesses fall in different banks, both complete in the same cycle.

When both accesses fall in the same bank, the primary access is served at once. The secondary access is parked in a one-entry holding register and served on the following cycle. During that following cycle a stall output tells both pipes to present nothing new. A bank collision therefore costs exactly one extra cycle.

Each port returns load data one cycle after its access is granted, marked by a per-port valid strobe. Tags, misses and refill are not handled here: the banks are plain synchronous RAM arrays.

Top module: `dual_pipe_bank_arbiter`

## Requirements
- R1: With 32-bit words and eight banks, byte address bits [4:2] select the bank and the bits above them select the row. Bits [1:0] are ignored, so every byte address within a word reaches the same word.
- R2: When both pipes request in one cycle and their bank fields differ, both accesses are performed in that cycle and stall stays low in the next cycle.
- R3: When both pipes request in one cycle with equal bank fields, the primary access is performed in that cycle. The secondary access is performed in the next cycle, and stall is high for exactly that one next cycle.
- R4: Requests presented on either port while stall is high are ignored. Nothing is written, and no read valid results from them.
- R5: A granted load raises that port's rvalid exactly one cycle after its grant, with the addressed word on rdata. A store, or a cycle with no grant, leaves rvalid low one cycle later.
- R6: When both pipes store to the same word in one cycle, the secondary pipe's data is what remains.
- R7: Same-bank collisions keep program order. A secondary load that follows a primary store to the same word returns the stored value. A primary load that meets a secondary store to the same word returns the older value.
- R8: After a synchronous active-high reset, stall, pa_rvalid and pb_rvalid are all low.
- R9: A request from only one pipe is performed in its cycle without raising stall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pa_req | input | 1 | Primary pipe access request |
| pa_we | input | 1 | Primary pipe: 1 store, 0 load |
| pa_addr | input | ADDR_W | Primary pipe byte address |
| pa_wdata | input | DATA_W | Primary pipe store data |
| pb_req | input | 1 | Secondary pipe access request |
| pb_we | input | 1 | Secondary pipe: 1 store, 0 load |
| pb_addr | input | ADDR_W | Secondary pipe byte address |
| pb_wdata | input | DATA_W | Secondary pipe store data |
| pa_rdata | output | DATA_W | Primary pipe load data |
| pa_rvalid | output | 1 | Primary pipe load data valid |
| pb_rdata | output | DATA_W | Secondary pipe load data |
| pb_rvalid | output | 1 | Secondary pipe load data valid |
| stall | output | 1 | A deferred secondary access is being served; hold new requests |

## Verification
The bench uses the default parameters: eight banks, 32-bit words and a 9-bit byte address, which gives 128 words in rows of 16. With such a small store, random pairs of accesses collide on a bank about one time in eight, and quite often hit the same word. This puts store-store and store-load ordering under collision within easy reach of random stimulus. Directed sequences add exact same-word collisions, requests driven during stall, and byte-offset aliasing.

// File: rtl/bank_arb_pkg.sv
package bank_arb_pkg;
  // Which requester owns a bank port in a given cycle
  typedef enum logic [1:0] {
    OWN_IDLE = 2'd0,
    OWN_PRI  = 2'd1,
    OWN_SEC  = 2'd2
  } bank_owner_e;
endpackage

// File: rtl/bank_arb_ram.sv
module bank_arb_ram #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  localparam int ROW_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [ROW_W-1:0]  row,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  // single port, read-before-write, registered read for block RAM inference
  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[row] <= wdata;
      rdata <= mem[row];
    end
  end
endmodule

// File: rtl/bank_arb_steer.sv
module bank_arb_steer
  import bank_arb_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  localparam int BANK_W = $clog2(NUM_BANKS)
) (
  input  logic              hold_v,
  input  logic              a_req,
  input  logic [BANK_W-1:0] a_bank,
  input  logic              b_req,
  input  logic [BANK_W-1:0] b_bank,
  input  logic [BANK_W-1:0] h_bank,
  output logic              a_go,
  output logic              b_go,
  output logic              defer,
  output logic [BANK_W-1:0] b_bank_eff,
  output bank_owner_e       owner [NUM_BANKS]
);
  logic accept;
  logic clash;

  always_comb begin
    accept     = !hold_v;
    clash      = a_req && b_req && (a_bank == b_bank);
    a_go       = accept && a_req;
    defer      = accept && clash;
    b_go       = hold_v || (accept && b_req && !clash);
    b_bank_eff = hold_v ? h_bank : b_bank;
  end

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_own
    always_comb begin
      if (b_go && b_bank_eff == BANK_W'(i))     owner[i] = OWN_SEC;
      else if (a_go && a_bank == BANK_W'(i))    owner[i] = OWN_PRI;
      else                                      owner[i] = OWN_IDLE;
    end
  end
endmodule

// File: rtl/bank_arb_return.sv
module bank_arb_return #(
  parameter int NUM_BANKS = 8,
  parameter int DATA_W    = 32,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          a_load,
  input  logic [BANK_W-1:0]             a_bank,
  input  logic                          b_load,
  input  logic [BANK_W-1:0]             b_bank,
  input  logic [NUM_BANKS*DATA_W-1:0]   bank_q,
  output logic [DATA_W-1:0]             a_rdata,
  output logic                          a_rvalid,
  output logic [DATA_W-1:0]             b_rdata,
  output logic                          b_rvalid
);
  logic [BANK_W-1:0] a_sel, b_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_rvalid <= 1'b0;
      b_rvalid <= 1'b0;
      a_sel    <= '0;
      b_sel    <= '0;
    end else begin
      a_rvalid <= a_load;
      b_rvalid <= b_load;
      if (a_load) a_sel <= a_bank;
      if (b_load) b_sel <= b_bank;
    end
  end

  assign a_rdata = bank_q[a_sel*DATA_W +: DATA_W];
  assign b_rdata = bank_q[b_sel*DATA_W +: DATA_W];
endmodule

// File: rtl/dual_pipe_bank_arbiter.sv
module dual_pipe_bank_arbiter
  import bank_arb_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pa_req,
  input  logic              pa_we,
  input  logic [ADDR_W-1:0] pa_addr,
  input  logic [DATA_W-1:0] pa_wdata,
  input  logic              pb_req,
  input  logic              pb_we,
  input  logic [ADDR_W-1:0] pb_addr,
  input  logic [DATA_W-1:0] pb_wdata,
  output logic [DATA_W-1:0] pa_rdata,
  output logic              pa_rvalid,
  output logic [DATA_W-1:0] pb_rdata,
  output logic              pb_rvalid,
  output logic              stall
);
  localparam int BANK_W = $clog2(NUM_BANKS);
  localparam int OFF_W  = $clog2(DATA_W/8);
  localparam int ROW_W  = ADDR_W - OFF_W - BANK_W;
  localparam int DEPTH  = 1 << ROW_W;

  logic [BANK_W-1:0] a_bank, b_bank;
  logic [ROW_W-1:0]  a_row, b_row;
  logic unused_offset;

  assign a_bank = pa_addr[OFF_W +: BANK_W];
  assign b_bank = pb_addr[OFF_W +: BANK_W];
  assign a_row  = pa_addr[OFF_W+BANK_W +: ROW_W];
  assign b_row  = pb_addr[OFF_W+BANK_W +: ROW_W];
  assign unused_offset = ^{pa_addr[OFF_W-1:0], pb_addr[OFF_W-1:0]};

  // one-entry holding register for a deferred secondary access
  logic              hold_v, hold_we;
  logic [BANK_W-1:0] hold_bank;
  logic [ROW_W-1:0]  hold_row;
  logic [DATA_W-1:0] hold_wd;

  logic              a_go, b_go, defer;
  logic [BANK_W-1:0] b_bank_eff;
  bank_owner_e       owner [NUM_BANKS];

  bank_arb_steer #(.NUM_BANKS(NUM_BANKS)) i_steer (
    .hold_v     (hold_v),
    .a_req      (pa_req),
    .a_bank     (a_bank),
    .b_req      (pb_req),
    .b_bank     (b_bank),
    .h_bank     (hold_bank),
    .a_go       (a_go),
    .b_go       (b_go),
    .defer      (defer),
    .b_bank_eff (b_bank_eff),
    .owner      (owner)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_v    <= 1'b0;
      hold_we   <= 1'b0;
      hold_bank <= '0;
      hold_row  <= '0;
      hold_wd   <= '0;
    end else begin
      hold_v <= defer;
      if (defer) begin
        hold_we   <= pb_we;
        hold_bank <= b_bank;
        hold_row  <= b_row;
        hold_wd   <= pb_wdata;
      end
    end
  end

  assign stall = hold_v;

  // effective secondary access: the held one, or the live one
  logic              b_we_eff;
  logic [ROW_W-1:0]  b_row_eff;
  logic [DATA_W-1:0] b_wd_eff;

  always_comb begin
    b_we_eff  = hold_v ? hold_we  : pb_we;
    b_row_eff = hold_v ? hold_row : b_row;
    b_wd_eff  = hold_v ? hold_wd  : pb_wdata;
  end

  logic [NUM_BANKS*DATA_W-1:0] bank_q;

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    logic              en, we;
    logic [ROW_W-1:0]  row;
    logic [DATA_W-1:0] wd;

    always_comb begin
      en  = 1'b0;
      we  = 1'b0;
      row = a_row;
      wd  = pa_wdata;
      case (owner[i])
        OWN_PRI: begin
          en = 1'b1;
          we = pa_we;
        end
        OWN_SEC: begin
          en  = 1'b1;
          we  = b_we_eff;
          row = b_row_eff;
          wd  = b_wd_eff;
        end
        default: ;
      endcase
    end

    bank_arb_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_ram (
      .clk   (clk),
      .en    (en),
      .we    (we),
      .row   (row),
      .wdata (wd),
      .rdata (bank_q[i*DATA_W +: DATA_W])
    );
  end

  bank_arb_return #(.NUM_BANKS(NUM_BANKS), .DATA_W(DATA_W)) i_ret (
    .clk      (clk),
    .rst      (rst),
    .a_load   (a_go && !pa_we),
    .a_bank   (a_bank),
    .b_load   (b_go && !b_we_eff),
    .b_bank   (b_bank_eff),
    .bank_q   (bank_q),
    .a_rdata  (pa_rdata),
    .a_rvalid (pa_rvalid),
    .b_rdata  (pb_rdata),
    .b_rvalid (pb_rvalid)
  );
endmodule

// File: rtl/bank_arb_chk.sv
module bank_arb_chk #(
  parameter int NUM_BANKS = 8,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              pa_req,
  input logic              pa_we,
  input logic [ADDR_W-1:0] pa_addr,
  input logic              pb_req,
  input logic              pb_we,
  input logic [ADDR_W-1:0] pb_addr,
  input logic              pa_rvalid,
  input logic              pb_rvalid,
  input logic              stall
);
  localparam int BANK_W = $clog2(NUM_BANKS);
  localparam int OFF_W  = $clog2(DATA_W/8);

  logic same_bank;
  assign same_bank = pa_addr[OFF_W +: BANK_W] == pb_addr[OFF_W +: BANK_W];

  // R3
  collide_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (!stall && pa_req && pb_req && same_bank) |=> stall);

  // R2
  parallel_nostall_chk: assert property (@(posedge clk) disable iff (rst)
    (!stall && pa_req && pb_req && !same_bank) |=> !stall);

  // R3
  one_cycle_stall_chk: assert property (@(posedge clk) disable iff (rst)
    stall |=> !stall);

  // R3
  deferred_load_chk: assert property (@(posedge clk) disable iff (rst)
    (!stall && pa_req && pb_req && same_bank && !pb_we) |=> (!pb_rvalid ##1 pb_rvalid));

  // R4
  stall_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    stall |=> !pa_rvalid);

  // R5
  pri_load_rv_chk: assert property (@(posedge clk) disable iff (rst)
    (!stall && pa_req && !pa_we) |=> pa_rvalid);

  // R5
  pri_store_norv_chk: assert property (@(posedge clk) disable iff (rst)
    (!stall && !(pa_req && !pa_we)) |=> !pa_rvalid);

  // R9
  solo_nostall_chk: assert property (@(posedge clk) disable iff (rst)
    (!stall && (pa_req != pb_req)) |=> !stall);
endmodule

bind dual_pipe_bank_arbiter bank_arb_chk #(
  .NUM_BANKS(NUM_BANKS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) i_chk (
  .clk(clk), .rst(rst),
  .pa_req(pa_req), .pa_we(pa_we), .pa_addr(pa_addr),
  .pb_req(pb_req), .pb_we(pb_we), .pb_addr(pb_addr),
  .pa_rvalid(pa_rvalid), .pb_rvalid(pb_rvalid), .stall(stall)
);

// File: tb/test_dual_pipe_bank_arbiter.sv
`timescale 1ns/1ps
module test_dual_pipe_bank_arbiter;
  localparam int NB = 8;
  localparam int DW = 32;
  localparam int AW = 9;
  localparam int NWORDS = 1 << (AW - 2);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pa_req = 0, pa_we = 0, pb_req = 0, pb_we = 0;
  logic [AW-1:0] pa_addr = '0, pb_addr = '0;
  logic [DW-1:0] pa_wdata = '0, pb_wdata = '0;
  logic [DW-1:0] pa_rdata, pb_rdata;
  logic pa_rvalid, pb_rvalid, stall;

  always #10 clk = ~clk;

  dual_pipe_bank_arbiter #(.NUM_BANKS(NB), .DATA_W(DW), .ADDR_W(AW)) i_dual_pipe_bank_arbiter (
    .clk(clk), .rst(rst),
    .pa_req(pa_req), .pa_we(pa_we), .pa_addr(pa_addr), .pa_wdata(pa_wdata),
    .pb_req(pb_req), .pb_we(pb_we), .pb_addr(pb_addr), .pb_wdata(pb_wdata),
    .pa_rdata(pa_rdata), .pa_rvalid(pa_rvalid),
    .pb_rdata(pb_rdata), .pb_rvalid(pb_rvalid), .stall(stall)
  );

  int total = 0;
  int fails = 0;
  string tag = "R8";

  // reference model, built from the requirements
  logic [DW-1:0] mem_m [NWORDS];
  logic          m_hold = 0, m_hwe = 0;
  int            m_hidx = 0;
  logic [DW-1:0] m_hwd = '0;
  logic          e_stall = 0, e_pav = 0, e_pbv = 0;
  logic [DW-1:0] e_pad = '0, e_pbd = '0;

  function automatic int word_of(input logic [AW-1:0] a);
    return int'(a[AW-1:2]);
  endfunction

  function automatic logic [2:0] bank_of(input logic [AW-1:0] a);
    return a[4:2];
  endfunction

  task automatic check(input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic ar, input logic aw, input logic [AW-1:0] aa, input logic [DW-1:0] ad,
                      input logic br, input logic bw, input logic [AW-1:0] ba, input logic [DW-1:0] bd);
    @(negedge clk);
    check("stall", DW'(stall), DW'(e_stall));
    check("pa_rvalid", DW'(pa_rvalid), DW'(e_pav));
    check("pb_rvalid", DW'(pb_rvalid), DW'(e_pbv));
    if (e_pav) check("pa_rdata", pa_rdata, e_pad);
    if (e_pbv) check("pb_rdata", pb_rdata, e_pbd);
    pa_req = ar; pa_we = aw; pa_addr = aa; pa_wdata = ad;
    pb_req = br; pb_we = bw; pb_addr = ba; pb_wdata = bd;
    e_stall = 0; e_pav = 0; e_pbv = 0;
    if (m_hold) begin
      if (m_hwe) mem_m[m_hidx] = m_hwd;
      else begin e_pbv = 1; e_pbd = mem_m[m_hidx]; end
      m_hold = 0;
    end else begin
      logic same;
      same = ar && br && (bank_of(aa) == bank_of(ba));
      if (ar) begin
        if (aw) mem_m[word_of(aa)] = ad;
        else begin e_pav = 1; e_pad = mem_m[word_of(aa)]; end
      end
      if (br) begin
        if (same) begin
          m_hold = 1; m_hwe = bw; m_hidx = word_of(ba); m_hwd = bd; e_stall = 1;
        end else if (bw) mem_m[word_of(ba)] = bd;
        else begin e_pbv = 1; e_pbd = mem_m[word_of(ba)]; end
      end
    end
  endtask

  task automatic idle();
    step(0, 0, '0, '0, 0, 0, '0, '0);
  endtask

  function automatic logic [AW-1:0] wa(input int w, input int off);
    return AW'(w * 4 + off);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    void'($urandom(32'h1bad5eed));
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;
    // R8: reset state observed on the first step
    tag = "R8";
    idle();

    // preload every word, two banks per cycle
    tag = "R2";
    for (int w = 0; w < NWORDS; w += 2)
      step(1, 1, wa(w, 0), DW'(32'hA000_0000 + w), 1, 1, wa(w + 1, 0), DW'(32'hA000_0000 + w + 1));

    // R9: one pipe at a time
    tag = "R9";
    step(1, 0, wa(5, 0), '0, 0, 0, '0, '0);
    step(0, 0, '0, '0, 1, 1, wa(9, 0), 32'h0000_9999);
    step(0, 0, '0, '0, 1, 0, wa(9, 0), '0);
    idle();

    // R2: different banks in parallel
    tag = "R2";
    step(1, 1, wa(16, 0), 32'h1111_0016, 1, 1, wa(21, 0), 32'h2222_0021);
    step(1, 0, wa(16, 0), '0, 1, 0, wa(21, 0), '0);
    idle();

    // R3: same bank, different rows
    tag = "R3";
    step(1, 0, wa(3, 0), '0, 1, 0, wa(11, 0), '0);
    idle();
    idle();

    // R6: both store the same word
    tag = "R6";
    step(1, 1, wa(40, 0), 32'hAAAA_0040, 1, 1, wa(40, 0), 32'hBBBB_0040);
    idle();
    step(1, 0, wa(40, 0), '0, 0, 0, '0, '0);
    idle();

    // R7: store then load same word, and load then store
    tag = "R7";
    step(1, 1, wa(50, 0), 32'hCAFE_0050, 1, 0, wa(50, 0), '0);
    idle();
    step(1, 0, wa(51, 0), '0, 1, 1, wa(51, 0), 32'hDEAD_0051);
    idle();
    step(0, 0, '0, '0, 1, 0, wa(51, 0), '0);
    idle();

    // R4: requests during stall must be ignored
    tag = "R4";
    step(1, 0, wa(60, 0), '0, 1, 0, wa(68, 0), '0);
    step(1, 1, wa(61, 0), 32'hBAD0_0061, 1, 1, wa(62, 0), 32'hBAD0_0062);
    step(1, 0, wa(61, 0), '0, 1, 0, wa(62, 0), '0);
    idle();

    // R1: byte offsets alias to the same word; bank from bits [4:2]
    tag = "R1";
    step(1, 1, wa(70, 3), 32'h7070_7070, 0, 0, '0, '0);
    step(1, 0, wa(70, 1), '0, 1, 0, wa(71, 2), '0);
    step(1, 0, wa(78, 0), '0, 1, 0, wa(70, 2), '0);
    idle();
    idle();

    // R5: mixed random traffic, stall cycles still driven
    tag = "R5";
    for (int i = 0; i < 600; i++) begin
      logic [AW-1:0] ra, rb;
      ra = AW'($urandom_range(0, (1 << AW) - 1));
      rb = ($urandom_range(0, 3) == 0) ? ra : AW'($urandom_range(0, (1 << AW) - 1));
      step(1'($urandom), 1'($urandom), ra, DW'($urandom), 1'($urandom), 1'($urandom), rb, DW'($urandom));
    end
    idle();
    idle();

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule